// File: doc/BRIEF.md
# Process-Tagged Page Translation Cache

This block keeps a small set of recently used virtual-to-physical page translations and answers lookups from them without going to memory. Each entry holds a virtual page number, the process tag it belongs to, a physical frame number and three permission bits. A lookup compares its page number and the current process tag against every stored entry at once. A hit produces the physical address in the same cycle as the request. It also reports the permission bits.

When no entry matches, the block raises a miss. An external table walker then supplies the translation through the fill port. A fill for a page and tag already present overwrites that entry in place. Otherwise the fill goes into the lowest-numbered empty slot, or, when all slots are full, into the least recently used one. Because entries carry a process tag, a context switch only has to change the current tag. Stale entries can be removed one at a time by page number and tag, by process tag, or all at once.

Top module: `tlb_top`

## Requirements
- R1: After synchronous reset every entry is empty, so every lookup reports a miss until a fill is made.
- R2: A lookup whose page number (address bits 31..12) and process tag match a valid entry reports hit in the same cycle. The physical address is then the entry's frame number in bits 31..12 above the unchanged address bits 11..0.
- R3: A lookup reports miss when no valid entry has both its page number and its process tag. For every valid lookup exactly one of hit, miss or fault is high.
- R4: A fill writes an entry that later lookups return. A fill whose page number and tag are already present replaces that entry instead of taking another slot.
- R5: A fill of a new translation goes to the lowest-numbered empty slot. When no slot is empty, it goes to the least recently used entry.
- R6: Every lookup that matches an entry, and every fill, makes that entry the most recently used. When a fill and a matching lookup share a cycle, only the fill counts.
- R7: Permission bits are bit 0 read, bit 1 write and bit 2 execute. A write lookup that matches an entry with bit 1 clear raises fault, with hit low and the address zero. A hit drives the entry's permission bits on `hit_perm`.
- R8: Invalidating by page number and tag removes only the matching entry, starting with the cycle after the request. A lookup in the request cycle still sees the entry.
- R9: A per-tag flush removes every entry of that tag from the next cycle on and keeps entries of other tags.
- R10: A full flush empties every entry from the next cycle on.
- R11: A fill requested in the same cycle as any invalidate or flush is dropped.
- R12: When no lookup is requested, hit, miss and fault are low and the address and permission outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is for a write access |
| lk_vaddr | input | 32 | Virtual address to translate |
| cur_asid | input | 8 | Process tag of the running context |
| hit | output | 1 | Translation found and access allowed |
| miss | output | 1 | No matching entry |
| prot_fault | output | 1 | Write to an entry without write permission |
| paddr | output | 32 | Physical address on hit, else zero |
| hit_perm | output | 3 | Permission bits of the hitting entry |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | 20 | Page number of the fill |
| fill_asid | input | 8 | Process tag of the fill |
| fill_pfn | input | 20 | Frame number of the fill |
| fill_perm | input | 3 | Permission bits of the fill |
| inv_valid | input | 1 | Invalidate one entry |
| inv_vpn | input | 20 | Page number to invalidate |
| inv_asid | input | 8 | Process tag to invalidate |
| flush_all | input | 1 | Empty all entries |
| flush_asid_valid | input | 1 | Empty all entries of one tag |
| flush_asid | input | 8 | Tag to flush |

## Verification
Lookups use boundary offsets (all zeros, all ones and mixed bits), so a corrupted offset can be told apart from a wrong frame number. The same page is probed under a foreign tag to separate page matching from tag matching. Full-buffer sequences interleave touches and fills, so that replacement of the least recently used entry differs from oldest-fill, lowest-index or most-recent replacement. Same-cycle combinations of lookup, invalidate and fill show the order in which they take effect. A long random stream over a small page and tag space then mixes every operation against the behavioural model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W   = 32;
    parameter int PAGE_W = 12;
    parameter int VPN_W  = VA_W - PAGE_W;
    parameter int PFN_W  = 20;
    parameter int PA_W   = PFN_W + PAGE_W;
    parameter int ASID_W = 8;
    parameter int N_ENT  = 16;

    typedef struct packed {
        logic ex;
        logic wr;
        logic rd;
    } perm_t;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        perm_t             perm;
    } entry_t;

    // index of the lowest set bit, 0 when none is set
    function automatic int lowest_set(input logic [63:0] v);
        int r = 0;
        for (int i = 63; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int N  = N_ENT,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              fill_we,
    input  logic [IW-1:0]     fill_idx,
    input  entry_t            fill_ent,
    input  logic              kill_all,
    input  logic              kill_tag_v,
    input  logic [ASID_W-1:0] kill_tag,
    input  logic              kill_one_v,
    input  logic [VPN_W-1:0]  kill_vpn,
    input  logic [ASID_W-1:0] kill_one_tag,
    output logic [N-1:0]      lk_match,
    output logic [N-1:0]      fl_match,
    output logic [N-1:0]      valid_vec,
    output entry_t            hit_ent
);
    entry_t ent [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ent[i].valid <= 1'b0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (kill_all
                    || (kill_tag_v && ent[i].asid == kill_tag)
                    || (kill_one_v && ent[i].vpn == kill_vpn && ent[i].asid == kill_one_tag))
                    ent[i].valid <= 1'b0;
                else if (fill_we && fill_idx == IW'(i))
                    ent[i] <= fill_ent;
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign valid_vec[g] = ent[g].valid;
        assign lk_match[g]  = ent[g].valid && ent[g].vpn == lk_vpn && ent[g].asid == lk_asid;
        assign fl_match[g]  = ent[g].valid && ent[g].vpn == fill_ent.vpn
                              && ent[g].asid == fill_ent.asid;
    end

    always_comb begin
        hit_ent = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) hit_ent = hit_ent | ent[i];
        end
    end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch_v,
    input  logic [IW-1:0] touch_idx,
    input  logic [N-1:0]  valid_vec,
    output logic [IW-1:0] victim_idx
);
    // age rank per entry: 0 = most recent, N-1 = least recent; always a permutation
    logic [IW-1:0] age [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) age[i] <= IW'(i);
        end else if (touch_v) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)         age[i] <= '0;
                else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!valid_vec[i] && !found) begin
                victim_idx = IW'(i);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < N; i++) begin
                if (age[i] == IW'(N - 1)) victim_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int N  = N_ENT,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              hit,
    output logic              miss,
    output logic              prot_fault,
    output logic [PA_W-1:0]   paddr,
    output logic [2:0]        hit_perm,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [2:0]        fill_perm,
    input  logic              inv_valid,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic              flush_all,
    input  logic              flush_asid_valid,
    input  logic [ASID_W-1:0] flush_asid
);
    logic [N-1:0]  lk_match, fl_match, valid_vec;
    entry_t        hit_ent, fill_ent;
    logic [IW-1:0] victim_idx, fill_idx, hit_idx, dup_idx;
    logic          any_hit, fill_we, maint, fault_c;

    assign fill_ent = '{valid: 1'b1, asid: fill_asid, vpn: fill_vpn,
                        pfn: fill_pfn, perm: perm_t'(fill_perm)};

    assign maint   = flush_all | flush_asid_valid | inv_valid;
    assign fill_we = fill_valid & ~maint;
    assign any_hit = |lk_match;
    assign hit_idx = IW'(lowest_set(64'(lk_match)));
    assign dup_idx = IW'(lowest_set(64'(fl_match)));
    assign fill_idx = (|fl_match) ? dup_idx : victim_idx;

    tlb_store #(.N(N)) u_store (
        .clk(clk), .rst(rst),
        .lk_vpn(lk_vaddr[VA_W-1:PAGE_W]), .lk_asid(cur_asid),
        .fill_we(fill_we), .fill_idx(fill_idx), .fill_ent(fill_ent),
        .kill_all(flush_all), .kill_tag_v(flush_asid_valid), .kill_tag(flush_asid),
        .kill_one_v(inv_valid), .kill_vpn(inv_vpn), .kill_one_tag(inv_asid),
        .lk_match(lk_match), .fl_match(fl_match), .valid_vec(valid_vec),
        .hit_ent(hit_ent)
    );

    tlb_lru #(.N(N)) u_lru (
        .clk(clk), .rst(rst),
        .touch_v(fill_we | (lk_valid & any_hit)),
        .touch_idx(fill_we ? fill_idx : hit_idx),
        .valid_vec(valid_vec),
        .victim_idx(victim_idx)
    );

    assign fault_c    = lk_valid & any_hit & lk_write & ~hit_ent.perm.wr;
    assign prot_fault = fault_c;
    assign hit        = lk_valid & any_hit & ~fault_c;
    assign miss       = lk_valid & ~any_hit;
    assign paddr      = hit ? {hit_ent.pfn, lk_vaddr[PAGE_W-1:0]} : '0;
    assign hit_perm   = hit ? 3'(hit_ent.perm) : 3'b000;
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
    import tlb_pkg::*;
#(
    parameter int N = N_ENT
) (
    input logic            clk,
    input logic            rst,
    input logic            lk_valid,
    input logic            lk_write,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            hit,
    input logic            miss,
    input logic            prot_fault,
    input logic [PA_W-1:0] paddr,
    input logic            flush_all,
    input logic [N-1:0]    valid_vec
);
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> valid_vec == '0);

    p_offset_kept_r2: assert property (@(posedge clk) disable iff (rst)
        hit |-> paddr[PAGE_W-1:0] == lk_vaddr[PAGE_W-1:0]);

    p_one_outcome_r3: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $countones({hit, miss, prot_fault}) == 1);

    p_fault_on_write_r7: assert property (@(posedge clk) disable iff (rst)
        prot_fault |-> lk_write && paddr == '0);

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> valid_vec == '0);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !hit && !miss && !prot_fault && paddr == '0);
endmodule

bind tlb_top tlb_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vaddr(lk_vaddr), .hit(hit), .miss(miss), .prot_fault(prot_fault),
    .paddr(paddr), .flush_all(flush_all), .valid_vec(valid_vec)
);

// File: tb/sim_tlb_top.sv
`timescale 1ns/1ps
module sim_tlb_top;
    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid, lk_write;
    logic [31:0] lk_vaddr;
    logic [7:0]  cur_asid;
    logic        hit, miss, prot_fault;
    logic [31:0] paddr;
    logic [2:0]  hit_perm;
    logic        fill_valid;
    logic [19:0] fill_vpn, fill_pfn;
    logic [7:0]  fill_asid;
    logic [2:0]  fill_perm;
    logic        inv_valid;
    logic [19:0] inv_vpn;
    logic [7:0]  inv_asid;
    logic        flush_all, flush_asid_valid;
    logic [7:0]  flush_asid;

    always #2.5 clk = ~clk;

    tlb_top u0 (.*);

    // behavioural model
    bit          m_v    [NE];
    logic [19:0] m_vpn  [NE];
    logic [7:0]  m_asid [NE];
    logic [19:0] m_pfn  [NE];
    logic [2:0]  m_perm [NE];
    int          recent [$];   // front = most recently used

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    task automatic clr_in();
        lk_valid = 0; lk_write = 0; lk_vaddr = '0; cur_asid = '0;
        fill_valid = 0; fill_vpn = '0; fill_asid = '0; fill_pfn = '0; fill_perm = '0;
        inv_valid = 0; inv_vpn = '0; inv_asid = '0;
        flush_all = 0; flush_asid_valid = 0; flush_asid = '0;
    endtask

    task automatic model_reset();
        recent = {};
        for (int i = 0; i < NE; i++) begin
            m_v[i] = 0;
            recent.push_back(i);
        end
    endtask

    function automatic int model_find(input logic [19:0] vpn, input logic [7:0] tag);
        int r = -1;
        for (int i = 0; i < NE; i++)
            if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == tag) r = i;
        return r;
    endfunction

    task automatic touch(input int idx);
        for (int k = 0; k < recent.size(); k++) begin
            if (recent[k] == idx) begin
                recent.delete(k);
                break;
            end
        end
        recent.push_front(idx);
    endtask

    task automatic model_update();
        int  mi, slot;
        mi = lk_valid ? model_find(lk_vaddr[31:12], cur_asid) : -1;
        for (int i = 0; i < NE; i++) begin
            if (flush_all) m_v[i] = 0;
            if (flush_asid_valid && m_asid[i] == flush_asid) m_v[i] = 0;
            if (inv_valid && m_vpn[i] == inv_vpn && m_asid[i] == inv_asid) m_v[i] = 0;
        end
        if (fill_valid && !(flush_all || flush_asid_valid || inv_valid)) begin
            slot = model_find(fill_vpn, fill_asid);
            if (slot < 0) begin
                for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) slot = i;
            end
            if (slot < 0) slot = recent[$];
            m_v[slot] = 1; m_vpn[slot] = fill_vpn; m_asid[slot] = fill_asid;
            m_pfn[slot] = fill_pfn; m_perm[slot] = fill_perm;
            touch(slot);
        end else if (mi >= 0) begin
            touch(mi);
        end
    endtask

    task automatic step(input string tag);
        logic [37:0] exp_v, got_v;
        int mi;
        #1;
        exp_v = '0;
        if (lk_valid) begin
            mi = model_find(lk_vaddr[31:12], cur_asid);
            if (mi < 0)                             exp_v = {3'b010, 32'h0, 3'b000};
            else if (lk_write && !m_perm[mi][1])    exp_v = {3'b001, 32'h0, 3'b000};
            else exp_v = {3'b100, m_pfn[mi], lk_vaddr[11:0], m_perm[mi]};
        end
        got_v = {hit, miss, prot_fault, paddr, hit_perm};
        n_chk++;
        if (got_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s: hit/miss/fault/paddr/perm got %h expected %h", tag, got_v, exp_v);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
        clr_in();
    endtask

    task automatic look(input logic [19:0] vpn, input logic [11:0] off,
                        input logic [7:0] tag, input bit wr, input string rq);
        lk_valid = 1; lk_write = wr; lk_vaddr = {vpn, off}; cur_asid = tag;
        step(rq);
    endtask

    task automatic put(input logic [19:0] vpn, input logic [7:0] tag,
                       input logic [19:0] pfn, input logic [2:0] pm);
        fill_valid = 1; fill_vpn = vpn; fill_asid = tag; fill_pfn = pfn; fill_perm = pm;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got hung expected done");
            finish_run();
        end
    end

    initial begin
        clr_in();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: empty after reset; R12: idle outputs quiet
        step("R12");
        look(20'h00010, 12'h000, 8'd1, 0, "R1");
        look(20'hFFFFF, 12'hFFF, 8'd0, 0, "R1");

        // R4: fills (slot 3 read-only)
        for (int k = 0; k < 4; k++) begin
            put(20'h00010 + 20'(k), 8'd1, 20'hA0000 + 20'(k), (k == 3) ? 3'b001 : 3'b011);
            step("R4");
        end
        // R2: hits with boundary offsets
        look(20'h00010, 12'h000, 8'd1, 0, "R2");
        look(20'h00011, 12'hFFF, 8'd1, 0, "R2");
        look(20'h00012, 12'h5A5, 8'd1, 0, "R2");
        // R3: foreign tag and absent page
        look(20'h00010, 12'h123, 8'd2, 0, "R3");
        look(20'h00099, 12'h123, 8'd1, 0, "R3");
        // R7: write protection
        look(20'h00013, 12'h010, 8'd1, 1, "R7");
        look(20'h00013, 12'h010, 8'd1, 0, "R7");
        look(20'h00010, 12'h010, 8'd1, 1, "R7");
        // R4: refill in place
        put(20'h00010, 8'd1, 20'hBBBBB, 3'b111);
        step("R4");
        look(20'h00010, 12'hABC, 8'd1, 1, "R4");
        // R11: fill dropped under invalidate
        put(20'h00050, 8'd1, 20'h12345, 3'b011);
        inv_valid = 1; inv_vpn = 20'h00099; inv_asid = 8'd1;
        step("R11");
        look(20'h00050, 12'h000, 8'd1, 0, "R11");
        // R8: invalidate with same-cycle lookup
        inv_valid = 1; inv_vpn = 20'h00011; inv_asid = 8'd1;
        look(20'h00011, 12'h001, 8'd1, 0, "R8");
        look(20'h00011, 12'h001, 8'd1, 0, "R8");
        look(20'h00012, 12'h001, 8'd1, 0, "R8");

        // R5/R6: fill past capacity with touches in between
        for (int k = 0; k < 14; k++) begin
            put(20'h00100 + 20'(k), 8'd2, 20'hC0000 + 20'(k), 3'b011);
            step("R5");
        end
        look(20'h00010, 12'h000, 8'd1, 0, "R6");
        look(20'h00100, 12'h000, 8'd2, 0, "R6");
        put(20'h00200, 8'd2, 20'hD0000, 3'b011);
        look(20'h00012, 12'h000, 8'd1, 0, "R6");
        for (int k = 1; k < 4; k++) begin
            put(20'h00200 + 20'(k), 8'd2, 20'hD0000 + 20'(k), 3'b011);
            step("R5");
        end
        for (int k = 0; k < 14; k++) look(20'h00100 + 20'(k), 12'h0F0, 8'd2, 0, "R5");
        for (int k = 0; k < 4; k++)  look(20'h00010 + 20'(k), 12'h0F0, 8'd1, 0, "R6");
        for (int k = 0; k < 4; k++)  look(20'h00200 + 20'(k), 12'h0F0, 8'd2, 0, "R6");

        // R9: flush one tag
        flush_asid_valid = 1; flush_asid = 8'd2;
        step("R9");
        look(20'h00101, 12'h000, 8'd2, 0, "R9");
        look(20'h00010, 12'h000, 8'd1, 0, "R9");
        // R10: flush all
        flush_all = 1;
        look(20'h00010, 12'h000, 8'd1, 0, "R10");
        look(20'h00010, 12'h000, 8'd1, 0, "R10");

        // mixed random stream
        for (int n = 0; n < 2500; n++) begin
            int op;
            op = $urandom_range(0, 99);
            lk_valid = ($urandom_range(0, 3) != 0);
            lk_write = $urandom_range(0, 1);
            lk_vaddr = {20'($urandom_range(0, 23)), 12'($urandom)};
            cur_asid = 8'($urandom_range(0, 2));
            if (op < 35) put(20'($urandom_range(0, 23)), 8'($urandom_range(0, 2)),
                             20'($urandom), 3'($urandom));
            else if (op < 40) begin
                inv_valid = 1; inv_vpn = 20'($urandom_range(0, 23));
                inv_asid = 8'($urandom_range(0, 2));
                if (op == 39) put(20'h00003, 8'd0, 20'h5, 3'b011);
            end else if (op == 40) begin
                flush_asid_valid = 1; flush_asid = 8'($urandom_range(0, 2));
            end else if (op == 41) flush_all = 1;
            step("R6");
        end

        done = 1;
        finish_run();
    end
endmodule